// File: doc/BRIEF.md
# Trimmed Time-of-Year Seconds Counter

This block keeps a running count of seconds in a slow clock domain fed by a 32.768 kHz source, and exposes that count through a small register interface clocked by a fast bus clock. A programmable trim prescaler divides the slow clock by trim+1. Every prescaler tick adds one to a 32-bit seconds count. With trim set to 32767, the count advances once per second. The counter runs from the slow clock only, so it keeps counting whatever the bus clock does.

Software reads the count, the trim value and a control/status word. It can write the count, the trim and the run-enable bit. Writes to the count or the trim do not take effect at once. Each one is held in a bus-side register and handed to the slow domain with a toggle request and a toggle acknowledge, each passing through a two-flop synchronizer. A busy flag for that register stays set until the acknowledge returns. Writes that arrive while the matching flag is set are dropped.

Each write hand-off is controlled by a two-state machine:
- Idle goes to Busy on an accepted write.
- Busy goes back to Idle when the synchronized acknowledge equals the request.

The count is brought to the bus side by a second two-state machine:
- Ask toggles a snapshot request and moves to Wait.
- Wait copies the captured slow-domain value into the bus-side snapshot when the acknowledge matches, then returns to Ask.

A bus-side detector watches the synchronized slow clock. It reports the slow clock as present after a transition, and as absent when no transition has been seen for a set window of bus cycles.

Top module: `trim_seconds_counter`

## Requirements
- R1: After reset, the control word (register select 0) reads 0, the trim (select 1) reads 0 and the count (select 2) reads 0. The control bits are: bit 0 run enable (read/write), bit 1 slow clock present, bit 2 count write busy, bit 3 trim write busy.
- R2: While running, the prescaler produces one tick every trim+1 slow clock cycles, and the count never steps by more than one per slow cycle except when it is loaded.
- R3: The count advances by one on each tick while run enable is set, and holds its value while run enable is clear.
- R4: A write to select 2 while the count is not busy sets control bit 2 on the next bus cycle. The bit clears once the new value has been loaded in the slow domain, and the count then reads the written value.
- R5: A write to select 1 while the trim is not busy sets control bit 3 on the next bus cycle. The bit clears after the slow domain has taken the value, and select 1 then reads the written value.
- R6: A write to the count or the trim while its own busy bit is set is ignored.
- R7: Loading the count restarts the prescaler, so the first increment after a load comes one full trim+1 period after it.
- R8: Control bit 1 becomes 1 within a few bus cycles of a slow clock transition. It becomes 0 once DET_WINDOW bus cycles pass with no transition.
- R9: The count read on the bus is always a coherent snapshot. Successive reads never go backwards and never jump by more than a few ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| slow_clk | input | 1 | 32.768 kHz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | 2 | Register select: 0 control, 1 trim, 2 count, 3 unused |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected register (combinational) |

## Verification
The assertions check four things on every bus cycle or slow cycle:
- a busy flag is raised after every accepted count or trim write;
- a held trim or count value is not disturbed by a write while busy;
- the count holds while the synchronized enable is clear;
- the count never steps by more than one per slow cycle outside a load.

Some behaviours can only be shown by the bench's scenarios:
- the tick rate for a given trim;
- the prescaler restart on a count load;
- loss and return of the slow clock as seen by the detector;
- the coherence of the bus-side count under fast ticking.

// File: rtl/toysec_pkg.sv
package toysec_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_TRIM  = 2'd1,
        REG_COUNT = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_BUSY = 1'b1
    } xfer_state_e;

    typedef enum logic {
        SN_ASK  = 1'b0,
        SN_WAIT = 1'b1
    } snap_state_e;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_CLKOK_BIT = 1;
    localparam int CTRL_CBUSY_BIT = 2;
    localparam int CTRL_TBUSY_BIT = 3;
endpackage

// File: rtl/toysec_sync.sv
module toysec_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/toysec_wr_xfer.sv
module toysec_wr_xfer
    import toysec_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             bus_clk,
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic             busy,
    output logic [WIDTH-1:0] hold,
    output logic             load_s
);
    xfer_state_e state, state_nx;
    logic req_t, req_s, seen_s, ack_b;

    // bus side: request register and state
    always_comb begin
        state_nx = state;
        unique case (state)
            XF_IDLE: if (wr_req)         state_nx = XF_BUSY;
            XF_BUSY: if (ack_b == req_t) state_nx = XF_IDLE;
        endcase
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= XF_IDLE;
            req_t <= 1'b0;
            hold  <= '0;
        end else begin
            state <= state_nx;
            if (state == XF_IDLE && wr_req) begin
                req_t <= ~req_t;
                hold  <= wr_data;
            end
        end
    end

    always_comb busy = (state == XF_BUSY);

    // slow side: detect request toggle, acknowledge by echoing it
    toysec_sync #(.WIDTH(1)) u_req_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(req_t), .q(req_s)
    );

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) seen_s <= 1'b0;
        else        seen_s <= req_s;
    end

    always_comb load_s = req_s ^ seen_s;

    toysec_sync #(.WIDTH(1)) u_ack_sync (
        .clk(bus_clk), .rst_n(rst_n), .d(seen_s), .q(ack_b)
    );
endmodule

// File: rtl/toysec_core.sv
module toysec_core #(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16
) (
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              run_b,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              trim_load,
    input  logic [TRIM_W-1:0] trim_val,
    output logic              run_s,
    output logic [CNT_W-1:0]  count_s
);
    logic [TRIM_W-1:0] trim_r;
    logic [TRIM_W-1:0] presc;
    logic              tick;

    toysec_sync #(.WIDTH(1)) u_run_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(run_b), .q(run_s)
    );

    // >= so that a trim lowered below the current phase still ticks
    always_comb tick = run_s && (presc >= trim_r);

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_r  <= '0;
            presc   <= '0;
            count_s <= '0;
        end else begin
            if (trim_load) trim_r <= trim_val;
            if (cnt_load) begin
                count_s <= cnt_val;
                presc   <= '0;
            end else if (tick) begin
                count_s <= count_s + CNT_W'(1);
                presc   <= '0;
            end else if (run_s) begin
                presc   <= presc + TRIM_W'(1);
            end
        end
    end
endmodule

// File: rtl/toysec_snap.sv
module toysec_snap
    import toysec_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             bus_clk,
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] slow_val,
    output logic [WIDTH-1:0] snap_b
);
    snap_state_e state, state_nx;
    logic req_t, req_s, seen_s, ack_b;
    logic [WIDTH-1:0] cap_s;

    always_comb begin
        state_nx = state;
        unique case (state)
            SN_ASK:  state_nx = SN_WAIT;
            SN_WAIT: if (ack_b == req_t) state_nx = SN_ASK;
        endcase
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SN_ASK;
            req_t  <= 1'b0;
            snap_b <= '0;
        end else begin
            state <= state_nx;
            if (state == SN_ASK) req_t <= ~req_t;
            if (state == SN_WAIT && ack_b == req_t) snap_b <= cap_s;
        end
    end

    toysec_sync #(.WIDTH(1)) u_req_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(req_t), .q(req_s)
    );

    // capture is frozen from the ack toggle until the next request
    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_s <= 1'b0;
            cap_s  <= '0;
        end else if (req_s != seen_s) begin
            seen_s <= req_s;
            cap_s  <= slow_val;
        end
    end

    toysec_sync #(.WIDTH(1)) u_ack_sync (
        .clk(bus_clk), .rst_n(rst_n), .d(seen_s), .q(ack_b)
    );
endmodule

// File: rtl/toysec_clkdet.sv
module toysec_clkdet #(
    parameter int WINDOW = 16384
) (
    input  logic bus_clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic clk_ok
);
    localparam int TW = $clog2(WINDOW + 1);
    logic          lvl, lvl_d, edge_seen;
    logic [TW-1:0] timer;

    toysec_sync #(.WIDTH(1)) u_lvl_sync (
        .clk(bus_clk), .rst_n(rst_n), .d(slow_clk), .q(lvl)
    );

    always_comb edge_seen = lvl ^ lvl_d;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_d  <= 1'b0;
            timer  <= '0;
            clk_ok <= 1'b0;
        end else begin
            lvl_d <= lvl;
            if (edge_seen) begin
                timer  <= '0;
                clk_ok <= 1'b1;
            end else if (timer == TW'(WINDOW)) begin
                clk_ok <= 1'b0;
            end else begin
                timer  <= timer + TW'(1);
            end
        end
    end
endmodule

// File: rtl/trim_seconds_counter.sv
module trim_seconds_counter
    import toysec_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TRIM_W     = 16,
    parameter int DET_WINDOW = 16384
) (
    input  logic             bus_clk,
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata
);
    reg_sel_e          sel;
    logic              run_b, clk_ok;
    logic              cnt_wr, trim_wr, cnt_busy, trim_busy;
    logic              cnt_load, trim_load, run_s;
    logic [CNT_W-1:0]  cnt_hold, count_s, count_b;
    logic [TRIM_W-1:0] trim_hold;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        cnt_wr  = bus_wr && (sel == REG_COUNT);
        trim_wr = bus_wr && (sel == REG_TRIM);
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n)                         run_b <= 1'b0;
        else if (bus_wr && sel == REG_CTRL) run_b <= bus_wdata[CTRL_RUN_BIT];
    end

    toysec_wr_xfer #(.WIDTH(CNT_W)) u_cnt_xfer (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .wr_req(cnt_wr), .wr_data(bus_wdata),
        .busy(cnt_busy), .hold(cnt_hold), .load_s(cnt_load)
    );

    toysec_wr_xfer #(.WIDTH(TRIM_W)) u_trim_xfer (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .wr_req(trim_wr), .wr_data(bus_wdata[TRIM_W-1:0]),
        .busy(trim_busy), .hold(trim_hold), .load_s(trim_load)
    );

    toysec_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_core (
        .slow_clk(slow_clk), .rst_n(rst_n), .run_b(run_b),
        .cnt_load(cnt_load), .cnt_val(cnt_hold),
        .trim_load(trim_load), .trim_val(trim_hold),
        .run_s(run_s), .count_s(count_s)
    );

    toysec_snap #(.WIDTH(CNT_W)) u_snap (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .slow_val(count_s), .snap_b(count_b)
    );

    toysec_clkdet #(.WINDOW(DET_WINDOW)) u_det (
        .bus_clk(bus_clk), .rst_n(rst_n), .slow_clk(slow_clk), .clk_ok(clk_ok)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]   = run_b;
                bus_rdata[CTRL_CLKOK_BIT] = clk_ok;
                bus_rdata[CTRL_CBUSY_BIT] = cnt_busy;
                bus_rdata[CTRL_TBUSY_BIT] = trim_busy;
            end
            REG_TRIM:  bus_rdata[TRIM_W-1:0] = trim_hold;
            REG_COUNT: bus_rdata = count_b;
            REG_NONE:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trim_seconds_counter_chk.sv
module trim_seconds_counter_chk #(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16
) (
    input logic              bus_clk,
    input logic              slow_clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              cnt_busy,
    input logic              trim_busy,
    input logic [CNT_W-1:0]  cnt_hold,
    input logic [TRIM_W-1:0] trim_hold,
    input logic              run_s,
    input logic              cnt_load,
    input logic [CNT_W-1:0]  count_s
);
    assert_count_busy_sets_R4: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !cnt_busy) |=> cnt_busy);

    assert_trim_busy_sets_R5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !trim_busy) |=> trim_busy);

    assert_trim_write_ignored_R6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && trim_busy) |=> $stable(trim_hold));

    assert_count_write_ignored_R6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && cnt_busy) |=> $stable(cnt_hold));

    assert_hold_when_stopped_R3: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!run_s && !cnt_load) |=> $stable(count_s));

    assert_single_step_R2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !cnt_load |=> (count_s == $past(count_s) || count_s == $past(count_s) + CNT_W'(1)));
endmodule

bind trim_seconds_counter trim_seconds_counter_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr),
    .cnt_busy(cnt_busy), .trim_busy(trim_busy),
    .cnt_hold(cnt_hold), .trim_hold(trim_hold),
    .run_s(run_s), .cnt_load(cnt_load), .count_s(count_s)
);

// File: tb/tb_trim_seconds_counter.sv
module tb_trim_seconds_counter;
    localparam int CNT_W = 32;
    localparam int WIN   = 64;

    logic             bus_clk = 1'b0;
    logic             slow_clk = 1'b0;
    logic             slow_run = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic             bus_wr = 1'b0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    trim_seconds_counter #(.CNT_W(CNT_W), .TRIM_W(16), .DET_WINDOW(WIN)) dut (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2 bus_clk = ~bus_clk;
    always begin
        #20;
        if (slow_run) slow_clk = ~slow_clk;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [CNT_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [CNT_W-1:0] c;
        for (int i = 0; i < 400; i++) begin
            @(negedge bus_clk);
            bus_read(2'd0, c);
            if (c[3:2] == 2'b00) break;
        end
    endtask

    task automatic slow_wait(input int n);
        repeat (n) @(posedge slow_clk);
        @(negedge bus_clk);
    endtask

    task automatic t_reset_r1();
        logic [CNT_W-1:0] v;
        @(negedge bus_clk);
        bus_read(2'd0, v); check(v == 0, "R1 ctrl", v, 0);
        bus_read(2'd1, v); check(v == 0, "R1 trim", v, 0);
        bus_read(2'd2, v); check(v == 0, "R1 count", v, 0);
    endtask

    task automatic t_clkdet_r8();
        logic [CNT_W-1:0] v;
        slow_run = 1'b1;
        repeat (30) @(negedge bus_clk);
        bus_read(2'd0, v); check(v[1] == 1'b1, "R8 present", v[1], 1);
        slow_run = 1'b0;
        repeat (WIN + 40) @(negedge bus_clk);
        bus_read(2'd0, v); check(v[1] == 1'b0, "R8 lost", v[1], 0);
        slow_run = 1'b1;
        repeat (30) @(negedge bus_clk);
        bus_read(2'd0, v); check(v[1] == 1'b1, "R8 back", v[1], 1);
    endtask

    task automatic t_trim_r5();
        logic [CNT_W-1:0] v;
        bus_write(2'd1, 3);
        bus_read(2'd0, v); check(v[3] == 1'b1, "R5 busy set", v[3], 1);
        wait_idle();
        bus_read(2'd0, v); check(v[3] == 1'b0, "R5 busy clear", v[3], 0);
        bus_read(2'd1, v); check(v == 3, "R5 trim value", v, 3);
    endtask

    task automatic t_count_r4();
        logic [CNT_W-1:0] v;
        bus_write(2'd2, 1000);
        bus_read(2'd0, v); check(v[2] == 1'b1, "R4 busy set", v[2], 1);
        wait_idle();
        slow_wait(6);
        bus_read(2'd2, v); check(v == 1000, "R4 loaded", v, 1000);
        slow_wait(20);
        bus_read(2'd2, v); check(v == 1000, "R3 hold when stopped", v, 1000);
    endtask

    task automatic t_ignore_r6();
        logic [CNT_W-1:0] v;
        bus_write(2'd2, 500);
        bus_write(2'd2, 777);
        wait_idle();
        slow_wait(6);
        bus_read(2'd2, v); check(v == 500, "R6 count write while busy", v, 500);
        bus_write(2'd1, 5);
        bus_write(2'd1, 9);
        wait_idle();
        bus_read(2'd1, v); check(v == 5, "R6 trim write while busy", v, 5);
        bus_write(2'd1, 3);
        wait_idle();
    endtask

    task automatic t_rate_r2();
        logic [CNT_W-1:0] v, c0, c1;
        bus_write(2'd0, 1);
        bus_read(2'd0, v); check(v[0] == 1'b1, "R3 enable readback", v[0], 1);
        slow_wait(8);
        bus_read(2'd2, c0);
        slow_wait(40);
        bus_read(2'd2, c1);
        check((c1 - c0) >= 9 && (c1 - c0) <= 11, "R2 trim 3 rate", c1 - c0, 10);
        bus_write(2'd1, 0);
        wait_idle();
        slow_wait(4);
        bus_read(2'd2, c0);
        slow_wait(20);
        bus_read(2'd2, c1);
        check((c1 - c0) >= 19 && (c1 - c0) <= 21, "R2 trim 0 rate", c1 - c0, 20);
    endtask

    task automatic t_coherent_r9();
        logic [CNT_W-1:0] prev, cur;
        int bad = 0;
        longint worst = 0;
        bus_read(2'd2, prev);
        for (int i = 0; i < 300; i++) begin
            @(negedge bus_clk);
            bus_read(2'd2, cur);
            if (cur < prev || (cur - prev) > 8) begin
                bad++;
                worst = cur - prev;
            end
            prev = cur;
        end
        check(bad == 0, "R9 coherent reads", worst, 0);
    endtask

    task automatic t_phase_r7();
        logic [CNT_W-1:0] v, c0;
        bus_write(2'd1, 39);
        wait_idle();
        slow_wait(4);
        bus_read(2'd2, c0);
        for (int i = 0; i < 3000; i++) begin
            @(negedge bus_clk);
            bus_read(2'd2, v);
            if (v != c0) break;
        end
        slow_wait(30);
        bus_write(2'd2, 100);
        wait_idle();
        slow_wait(25);
        bus_read(2'd2, v); check(v == 100, "R7 no early tick", v, 100);
        slow_wait(25);
        bus_read(2'd2, v); check(v == 101, "R7 tick after full period", v, 101);
    endtask

    initial begin
        repeat (5) @(negedge bus_clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_clkdet_r8();
        t_trim_r5();
        t_count_r4();
        t_ignore_r6();
        t_rate_r2();
        t_coherent_r9();
        t_phase_r7();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule